// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor core that completes one instruction in every clock cycle. It supports eight instructions. Five are register-register operations (add, subtract, bitwise and, bitwise or, set-on-signed-less-than). The other three are load word, store word and branch-if-equal. The core holds the program counter, a 32-entry register file with two read ports and one write port, an ALU with a zero flag, a 16-to-32-bit sign extender and the next-PC logic. It also holds the multiplexers that pick the destination register, the second ALU operand and the write-back source.

The core sees two memories, and both respond in the same cycle. The instruction port presents a PC and expects the matching word back combinationally. The data port presents an address, store data and separate read and write strobes. It expects load data combinationally, and the write is committed on the next rising clock edge. An active-low reset is applied asynchronously and released through a two-stage synchronizer. The core starts fetching at address zero two rising edges after the reset input goes high.

Top module: `sc_cpu_core`

## Requirements
- R1: While reset is held, and until the synchronizer releases it, the core presents PC 0 with both data strobes low. On release, all 32 registers read as zero.
- R2: Any instruction that does not take a branch advances the PC by 4 at the next rising edge.
- R3: Opcode 0x00 with funct 0x20, 0x22, 0x24 or 0x25 writes rd (bits 15:11) with rs+rt, rs-rt, rs AND rt or rs OR rt. rs is bits 25:21, rt is bits 20:16 and funct is bits 5:0. Sums wrap modulo 2^32.
- R4: Opcode 0x00 with funct 0x2A writes rd with 1 when rs is less than rt as signed 32-bit values, and with 0 otherwise.
- R5: Opcode 0x23 raises the data read strobe and drives the data address with rs plus bits 15:0 sign-extended. It then writes the returned data word into rt.
- R6: Opcode 0x2B raises the data write strobe, drives the same kind of address as R5 and drives rt as the write data. The read and write strobes are never high together.
- R7: When opcode 0x04 finds rs equal to rt, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2. Otherwise the next PC is PC+4.
- R8: Register 0 always reads as zero. Writes aimed at it are dropped.
- R9: Any other opcode, and opcode 0x00 with any other funct, writes no register and no memory.
- R10: A register write lands on the clock edge that ends its instruction. An instruction that reads its own destination sees the old value, and the next instruction sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Program counter driven to instruction memory |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the next rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |

## Verification
The embedded properties assume that both memories answer within the same cycle. They also assume that every fetch and data address falls inside the memory, so imem_rdata and dmem_rdata never carry unknown values. The constrained-random programs keep to these assumptions. Every load and store uses either register 0 or a base register that is loaded once with 64 and never overwritten, with word-aligned offsets chosen so that addresses stay between 0 and 124. Branches jump forward by at most three words, and every program ends in a self-loop, so fetches never leave the loaded code.

// File: rtl/sc_cpu_pkg.sv
package sc_cpu_pkg;

  // Opcode and funct codes of the supported subset
  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // Instruction field positions (fixed by the encoding)
  localparam int OPC_LSB = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int IMM_W   = 16;
  localparam int FN_W    = 6;

  typedef enum logic [1:0] {
    ACLS_ADD   = 2'd0,
    ACLS_SUB   = 2'd1,
    ACLS_FUNCT = 2'd2
  } alu_class_e;

  typedef enum logic [2:0] {
    AF_ADD = 3'd0,
    AF_SUB = 3'd1,
    AF_AND = 3'd2,
    AF_OR  = 3'd3,
    AF_SLT = 3'd4
  } alu_fn_e;

  typedef struct packed {
    logic       reg_write;
    logic       dst_is_rd;
    logic       b_is_imm;
    logic       wb_from_mem;
    logic       mem_rd;
    logic       mem_wr;
    logic       is_branch;
    alu_class_e alu_class;
  } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_cpu_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl           = '0;
    ctrl.alu_class = ACLS_ADD;
    unique case (opcode)
      OPC_REG: begin
        ctrl.reg_write = 1'b1;
        ctrl.dst_is_rd = 1'b1;
        ctrl.alu_class = ACLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.reg_write   = 1'b1;
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.mem_rd      = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_wr   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_class = ACLS_SUB;
      end
      default: ctrl = ctrl;
    endcase
  end

endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
  import sc_cpu_pkg::*;
(
  input  alu_class_e       alu_class,
  input  logic [FN_W-1:0]  funct,
  output alu_fn_e          fn,
  output logic             fn_ok
);

  always_comb begin
    fn    = AF_ADD;
    fn_ok = 1'b1;
    unique case (alu_class)
      ACLS_ADD: fn = AF_ADD;
      ACLS_SUB: fn = AF_SUB;
      default: begin
        unique case (funct)
          FN_ADD:  fn = AF_ADD;
          FN_SUB:  fn = AF_SUB;
          FN_AND:  fn = AF_AND;
          FN_OR:   fn = AF_OR;
          FN_SLT:  fn = AF_SLT;
          default: fn_ok = 1'b0;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);

  logic [W-1:0] diff;
  logic         lt_signed;

  assign diff      = a - b;
  assign lt_signed = $signed(a) < $signed(b);

  always_comb begin
    unique case (fn)
      AF_ADD:  y = a + b;
      AF_SUB:  y = diff;
      AF_AND:  y = a & b;
      AF_OR:   y = a | b;
      AF_SLT:  y = {{(W-1){1'b0}}, lt_signed};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [W-1:0]  rdata0,
  output logic [W-1:0]  rdata1
);

  logic [W-1:0] reg_q [NREGS];

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    if (gi == 0) begin : g_zero
      assign reg_q[gi] = '0;
    end else begin : g_store
      logic         wr_en;
      logic [W-1:0] reg_d;

      assign wr_en = we && (waddr == AW'(gi));

      always_comb begin
        reg_d = reg_q[gi];
        if (wr_en) reg_d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q[gi] <= '0;
        else        reg_q[gi] <= reg_d;
      end
    end
  end

  assign rdata0 = reg_q[raddr0];
  assign rdata1 = reg_q[raddr1];

  // R10: a committed write is what the following cycle reads back
  p_write_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0) |=> ((raddr0 == $past(waddr)) -> (rdata0 == $past(wdata))));

endmodule

// File: rtl/sc_cpu_core.sv
module sc_cpu_core
  import sc_cpu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int RAW            = $clog2(NREGS);
  localparam int SYNC_STAGES    = 2;
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  // Reset synchronizer: asserts at once, releases on the clock
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rsync_q[SYNC_STAGES-1];

  // Instruction fields
  logic [XLEN-1:0]  instr;
  logic [5:0]       opcode;
  logic [RAW-1:0]   rs, rt, rd;
  logic [FN_W-1:0]  funct;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  imm_ext;

  assign instr   = imem_rdata;
  assign opcode  = instr[OPC_LSB +: 6];
  assign rs      = instr[RS_LSB +: RAW];
  assign rt      = instr[RT_LSB +: RAW];
  assign rd      = instr[RD_LSB +: RAW];
  assign funct   = instr[FN_W-1:0];
  assign imm     = instr[IMM_W-1:0];
  assign imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

  // Control
  ctrl_t   ctrl;
  alu_fn_e alu_fn;
  logic    fn_ok;

  sc_main_dec i_dec (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  sc_alu_ctrl i_alu_ctrl (
    .alu_class (ctrl.alu_class),
    .funct     (funct),
    .fn        (alu_fn),
    .fn_ok     (fn_ok)
  );

  // Register file and ALU
  logic [XLEN-1:0] rf_rd0, rf_rd1, alu_b, alu_y, wb_data;
  logic [RAW-1:0]  rf_waddr;
  logic            rf_we, alu_zero;

  assign rf_waddr = ctrl.dst_is_rd ? rd : rt;
  assign rf_we    = ctrl.reg_write && fn_ok && core_rst_n;
  assign wb_data  = ctrl.wb_from_mem ? dmem_rdata : alu_y;
  assign alu_b    = ctrl.b_is_imm ? imm_ext : rf_rd1;

  sc_regfile #(.W(XLEN), .NREGS(NREGS)) i_rf (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .we     (rf_we),
    .waddr  (rf_waddr),
    .wdata  (wb_data),
    .raddr0 (rs),
    .raddr1 (rt),
    .rdata0 (rf_rd0),
    .rdata1 (rf_rd1)
  );

  sc_alu #(.W(XLEN)) i_alu (
    .a    (rf_rd0),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // Next PC
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_target;
  logic            br_take;

  assign pc_plus4  = pc_q + PC_STEP;
  assign br_target = pc_plus4 + (imm_ext << 2);
  assign br_take   = ctrl.is_branch && alu_zero;

  always_comb begin
    pc_d = pc_plus4;
    if (br_take) pc_d = br_target;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) pc_q <= '0;
    else             pc_q <= pc_d;
  end

  // Memory ports
  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rf_rd1;
  assign dmem_we    = ctrl.mem_wr && core_rst_n;
  assign dmem_re    = ctrl.mem_rd && core_rst_n;

  // R2: straight-line flow advances by one word
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    !br_take |=> (pc_q == $past(pc_q) + PC_STEP));

  // R7: taken branch lands on the offset target
  p_branch_target_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    br_take |=> (pc_q == $past(pc_q) + PC_STEP + ($past(imm_ext) << 2)));

  // R6: never a load and a store in the same cycle
  p_mem_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dmem_we, dmem_re}));

  // R8: storing register 0 always sends zero
  p_store_r0_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (dmem_we && rt == '0) |-> (dmem_wdata == '0));

  // R1: no memory strobes before the synchronizer releases
  p_quiet_reset_r1: assert property (@(posedge clk)
    !core_rst_n |-> (!dmem_we && !dmem_re && imem_addr == '0));

endmodule

// File: tb/test_sc_cpu_core.sv
module test_sc_cpu_core;

  localparam int CLK_P   = 10;
  localparam int IM_WORDS = 256;
  localparam int DM_WORDS = 64;
  localparam int N_RAND  = 20;
  localparam int BODY    = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  logic [31:0] imem [IM_WORDS];
  logic [31:0] dmem [DM_WORDS];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  sc_cpu_core i_sc_cpu_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_re    (dmem_re),
    .dmem_rdata (dmem_rdata)
  );

  // Reference model state
  logic [31:0] mreg [32];
  logic [31:0] mmem [DM_WORDS];
  logic [31:0] mpc;
  int          plen;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h pc=%08h", tag, act, exp, mpc);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] sx(input logic [31:0] w);
    return {{16{w[15]}}, w[15:0]};
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    if (w[31:26] == 6'h00) begin
      if (w[5:0] == 6'h2A) return "R4";
      if (w[5:0] inside {6'h20, 6'h22, 6'h24, 6'h25}) return "R3";
      return "R9";
    end
    if (w[31:26] == 6'h23) return "R5";
    if (w[31:26] == 6'h2B) return (w[20:16] == 5'd0) ? "R8" : "R6";
    if (w[31:26] == 6'h04) return "R7";
    return "R9";
  endfunction

  localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

  task automatic emit(input logic [31:0] w);
    imem[plen] = w;
    plen++;
  endtask

  task automatic emit_dump();
    for (int k = 0; k < 32; k++) emit(enc_i(6'h2B, 0, k, 128 + 4*k));
    emit(HALT);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < IM_WORDS; i++) imem[i] = 32'h0;
    plen = 0;
  endtask

  task automatic set_mem(input int idx, input logic [31:0] v);
    dmem[idx] <= v;
    mmem[idx] = v;
  endtask

  // One architectural step of the reference model
  task automatic model_step(input logic [31:0] w);
    logic [31:0] a, b, npc, ad;
    int rs, rt, rd;
    rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
    a = mreg[rs]; b = mreg[rt];
    npc = mpc + 32'd4;
    ad = a + sx(w);
    case (w[31:26])
      6'h00: begin
        case (w[5:0])
          6'h20: if (rd != 0) mreg[rd] = a + b;
          6'h22: if (rd != 0) mreg[rd] = a - b;
          6'h24: if (rd != 0) mreg[rd] = a & b;
          6'h25: if (rd != 0) mreg[rd] = a | b;
          6'h2A: if (rd != 0) mreg[rd] = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: ;
        endcase
      end
      6'h23: if (rt != 0) mreg[rt] = mmem[ad[7:2]];
      6'h2B: mmem[ad[7:2]] = b;
      6'h04: if (a == b) npc = mpc + 32'd4 + (sx(w) << 2);
      default: ;
    endcase
    mpc = npc;
  endtask

  // Reset, then run the loaded program until its final self-loop
  task automatic run_prog();
    logic [31:0] w, ad;
    string t, ftag;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
    mpc = 32'h0;
    repeat (3) begin
      @(negedge clk);
      chk(imem_addr == 32'h0, "R1", imem_addr, 32'h0);
      chk(dmem_we == 1'b0 && dmem_re == 1'b0, "R1", {30'd0, dmem_we, dmem_re}, 32'h0);
    end
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1: synchronizer still holding the core one edge after release
    chk(imem_addr == 32'h0 && !dmem_we && !dmem_re, "R1", imem_addr, 32'h0);
    @(posedge clk);
    ftag = "R2";
    for (int cyc = 0; cyc < 600; cyc++) begin
      @(negedge clk);
      w = imem[mpc[9:2]];
      t = tag_of(w);
      chk(imem_addr == mpc, ftag, imem_addr, mpc);
      ad = mreg[w[25:21]] + sx(w);
      if (w[31:26] == 6'h2B) begin
        chk(dmem_we && !dmem_re, t, {30'd0, dmem_we, dmem_re}, 32'h2);
        chk(dmem_addr == ad, t, dmem_addr, ad);
        chk(dmem_wdata == mreg[w[20:16]], t, dmem_wdata, mreg[w[20:16]]);
      end else if (w[31:26] == 6'h23) begin
        chk(dmem_re && !dmem_we, t, {30'd0, dmem_we, dmem_re}, 32'h1);
        chk(dmem_addr == ad, t, dmem_addr, ad);
      end else begin
        chk(!dmem_we && !dmem_re, t, {30'd0, dmem_we, dmem_re}, 32'h0);
      end
      if (w == HALT) break;
      ftag = (w[31:26] == 6'h04) ? "R7" : "R2";
      model_step(w);
    end
  endtask

  task automatic fill_rand_mem();
    set_mem(0, 32'd64);
    for (int i = 1; i < DM_WORDS; i++) set_mem(i, $urandom);
  endtask

  task automatic rand_addr(output int base, output int off);
    if ($urandom_range(1, 0) == 1) begin
      base = 0;  off = 4 * int'($urandom_range(31, 0));
    end else begin
      base = 31; off = 4 * int'($urandom_range(31, 0)) - 64;
    end
  endtask

  initial begin
    int b, o, pick;
    logic [5:0] fns [6];
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24;
    fns[3] = 6'h25; fns[4] = 6'h2A; fns[5] = 6'h21;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;

    // R1: registers read as zero right after reset (dump only)
    clear_prog();
    fill_rand_mem();
    emit_dump();
    run_prog();

    // Directed arithmetic corners: R3 R4 R8 R9 R10
    clear_prog();
    set_mem(1, 32'h7FFF_FFFF); set_mem(2, 32'h8000_0000);
    set_mem(3, 32'hFFFF_FFFF); set_mem(4, 32'h0000_0001);
    emit(enc_i(6'h23, 0, 1, 4));  emit(enc_i(6'h23, 0, 2, 8));
    emit(enc_i(6'h23, 0, 3, 12)); emit(enc_i(6'h23, 0, 4, 16));
    emit(enc_r(6'h20, 5, 1, 4));   // wraps to 0x80000000
    emit(enc_r(6'h22, 6, 2, 4));   // wraps to 0x7FFFFFFF
    emit(enc_r(6'h2A, 7, 2, 1));   // most negative < most positive
    emit(enc_r(6'h2A, 8, 1, 2));
    emit(enc_r(6'h2A, 9, 3, 4));   // -1 < 1
    emit(enc_r(6'h24, 10, 3, 1));
    emit(enc_r(6'h25, 11, 2, 4));
    emit(enc_r(6'h20, 0, 1, 1));   // R8 write to r0 dropped
    emit(enc_i(6'h2B, 0, 0, 20));
    emit({6'h3F, 5'd1, 5'd12, 16'h1234});  // R9 unknown opcode
    emit(enc_r(6'h00, 12, 1, 1));           // R9 unknown funct
    emit(enc_r(6'h20, 13, 13, 4));          // R10 own destination
    emit(enc_r(6'h20, 13, 13, 13));
    emit_dump();
    run_prog();

    // Directed branches and negative offsets: R5 R6 R7
    clear_prog();
    fill_rand_mem();
    set_mem(1, 32'd3); set_mem(2, 32'd1);
    emit(enc_i(6'h23, 0, 31, 0));
    emit(enc_i(6'h23, 0, 1, 4));
    emit(enc_i(6'h23, 0, 2, 8));
    emit(enc_r(6'h22, 1, 1, 2));           // loop body
    emit(enc_i(6'h04, 1, 0, 1));           // exit when zero
    emit(enc_i(6'h04, 0, 0, -3));          // backward
    emit(enc_i(6'h04, 1, 2, 2));           // not taken
    emit(enc_i(6'h2B, 31, 2, -60));
    emit(enc_i(6'h23, 31, 3, -60));
    emit_dump();
    run_prog();

    // Constrained random programs
    for (int p = 0; p < N_RAND; p++) begin
      clear_prog();
      fill_rand_mem();
      emit(enc_i(6'h23, 0, 31, 0));
      for (int n = 0; n < BODY; n++) begin
        pick = int'($urandom_range(9, 0));
        if (pick < 5) begin
          emit(enc_r(fns[$urandom_range(pick == 0 ? 5 : 4, 0)],
                     int'($urandom_range(30, 1)), int'($urandom_range(31, 0)),
                     int'($urandom_range(31, 0))));
        end else if (pick < 7) begin
          rand_addr(b, o);
          emit(enc_i(6'h23, b, int'($urandom_range(30, 1)), o));
        end else if (pick < 9) begin
          rand_addr(b, o);
          emit(enc_i(6'h2B, b, int'($urandom_range(31, 0)), o));
        end else begin
          b = int'($urandom_range(31, 0));
          o = ($urandom_range(1, 0) == 1) ? b : int'($urandom_range(31, 0));
          emit(enc_i(6'h04, b, o, int'($urandom_range(3, 0))));
        end
      end
      emit_dump();
      run_prog();
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired, run did not complete");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule